// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block is a bank of eight 32-bit event counters for one cache slice, reached through a simple register read/write port. Each counter has an 8-bit selector that picks one of seven event strobes: a cycle strobe, four read-hit and read-miss strobes (plain and data-side) and two write strobes. Each counter has its own count enable and its own interrupt enable. A global enable bit gates every counter at once. A write-one pulse clears all counts and flags in a single cycle.

An odd counter can be ganged to the even counter directly below it. The odd counter then counts the wraps of the even counter, so the pair forms a 64-bit counter. Software reads the high word from the odd counter and the low word from the even counter. Each counter sets a sticky overflow flag. By default the flag is set on a wrap. Optionally it is set on every change of the counter's top bit, which lets software leave a 32-bit counter free-running and still track it with one interrupt every half range. The flags are cleared by writing ones. One interrupt line is driven from the flags whose interrupt enables are set.

A few registers are plain storage with no effect on counting: a spare control word, six address filter words and one control word per counter.

Top module: `evctr_bank`

## Requirements
- R1: After reset every counter, count enable, interrupt enable, gang bit, top-bit mode bit, selector and overflow flag reads 0, and `irq_o` is low. A read from any offset with no register behind it returns 0.
- R2: Counter n (value register at 0x420 + 8n, selector at 0x220 + 8n) increases by exactly one on each clock where the global enable, its count enable and its selected strobe are all 1. The selector codes are 0x01 for `evt_i[0]` (cycles) and 0x20 through 0x25 for `evt_i[1]` through `evt_i[6]`. Every other code, 0x00 included, counts nothing.
- R3: Count enables are set by writing ones to 0x508 and cleared by writing ones to 0x50C, one bit per counter. Interrupt enables work the same way at 0x510 and 0x514. Zero bits in such a write change nothing, and both addresses of a pair read back the current mask.
- R4: Bit 0 of 0x500 is the global enable; while it is 0, no counter changes except by a direct write. Writing 1 to bit 1 of 0x500 clears every counter and every overflow flag on that clock. Bit 1 always reads back as 0.
- R5: A write to a counter's value register loads that value on the write clock and takes priority over an increment in the same clock. The loaded value reads back at the same offset.
- R6: When bit k of the gang register 0x718 is 1 for an odd k, counter k increments once per wrap of counter k-1, provided counter k is itself enabled, and ignores its own selected strobe. Gang bits at even positions are stored but have no effect.
- R7: In the default mode, counter n sets overflow flag n (bit n of 0x740) when it increments from all ones to zero. Only this wrap sets the flag.
- R8: When bit n of 0x96C is 1, flag n is set each time an increment changes bit 31 of counter n, whether from 0 to 1 or from 1 to 0.
- R9: Overflow flags are cleared by writing 1 to their bits in 0x740, and zero bits leave flags unchanged. If a flag is set and cleared in the same clock, it ends up set.
- R10: `irq_o` is high while any overflow flag is set together with its interrupt enable. It stays high until those flags are cleared.
- R11: The spare word at 0x504, the six filter words at 0x300 + 4i (i = 0..5) and the per-counter control words at 0x120 + 8n read back what was written, and selectors read back their low 8 bits. None of these changes counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe, acts on the rising clock edge |
| reg_addr | input | 12 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_i | input | 7 | Event strobes: bit 0 cycles, bits 1..6 the cache events |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Some properties are checked on every cycle. On a cycle without a register write, no counter moves by more than one. A disabled bank freezes all counters. Flags never fall, and a raised interrupt holds. A value write lands on the next edge, and the clear pulse empties counters and flags.

Other behaviour is shown only by the directed scenarios. These cover the mapping of selector codes to strobes and the carry path of a ganged pair. They also cover the exact clock on which wrap or top-bit mode raises a flag, the set-over-clear race in the flag register, and the read-back of the storage registers.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  localparam int unsigned NCTR = 8;
  localparam int unsigned CW   = 32;
  localparam int unsigned SELW = 8;
  localparam int unsigned NEV  = 7;
  localparam int unsigned AW   = 12;
  localparam int unsigned DW   = 32;
  localparam int unsigned NFLT = 6;

  // Register offsets (software decodes these)
  localparam logic [AW-1:0] A_CTRL  = 12'h500;
  localparam logic [AW-1:0] A_SPARE = 12'h504;
  localparam logic [AW-1:0] A_ENSET = 12'h508;
  localparam logic [AW-1:0] A_ENCLR = 12'h50C;
  localparam logic [AW-1:0] A_IESET = 12'h510;
  localparam logic [AW-1:0] A_IECLR = 12'h514;
  localparam logic [AW-1:0] A_GANG  = 12'h718;
  localparam logic [AW-1:0] A_OVF   = 12'h740;
  localparam logic [AW-1:0] A_MSBM  = 12'h96C;
  localparam logic [AW-1:0] A_FLT   = 12'h300;
  localparam logic [AW-1:0] A_CCTL  = 12'h120;
  localparam logic [AW-1:0] A_ESEL  = 12'h220;
  localparam logic [AW-1:0] A_VAL   = 12'h420;

  // Selector codes
  localparam logic [SELW-1:0] SEL_CYC     = 8'h01;
  localparam logic [SELW-1:0] SEL_RD_HIT  = 8'h20;
  localparam logic [SELW-1:0] SEL_RD_MISS = 8'h21;
  localparam logic [SELW-1:0] SEL_DR_HIT  = 8'h22;
  localparam logic [SELW-1:0] SEL_DR_MISS = 8'h23;
  localparam logic [SELW-1:0] SEL_WR_HIT  = 8'h24;
  localparam logic [SELW-1:0] SEL_WR_MISS = 8'h25;

  function automatic logic pick_event(input logic [SELW-1:0] sel,
                                      input logic [NEV-1:0]  ev);
    logic hit;
    hit = 1'b0;
    case (sel)
      SEL_CYC:     hit = ev[0];
      SEL_RD_HIT:  hit = ev[1];
      SEL_RD_MISS: hit = ev[2];
      SEL_DR_HIT:  hit = ev[3];
      SEL_DR_MISS: hit = ev[4];
      SEL_WR_HIT:  hit = ev[5];
      SEL_WR_MISS: hit = ev[6];
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/evctr_cfg.sv
module evctr_cfg import evctr_pkg::*; #(
  parameter int unsigned N     = NCTR,
  parameter int unsigned SEL_W = SELW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic                     glob_en_o,
  output logic                     clr_all_o,
  output logic [N-1:0]             cnt_en_o,
  output logic [N-1:0]             int_en_o,
  output logic [N-1:0]             gang_o,
  output logic [N-1:0]             msb_mode_o,
  output logic [N-1:0][SEL_W-1:0]  sel_o,
  output logic [DW-1:0]            rdata_o
);
  logic                      glob_q,  glob_d;
  logic [N-1:0]              en_q,    en_d;
  logic [N-1:0]              ie_q,    ie_d;
  logic [N-1:0]              gang_q,  gang_d;
  logic [N-1:0]              msb_q,   msb_d;
  logic [DW-1:0]             spare_q, spare_d;
  logic [NFLT-1:0][DW-1:0]   flt_q,   flt_d;
  logic [N-1:0][DW-1:0]      cctl_q,  cctl_d;
  logic [N-1:0][SEL_W-1:0]   sel_q,   sel_d;

  // next state
  always_comb begin
    glob_d  = glob_q;
    en_d    = en_q;
    ie_d    = ie_q;
    gang_d  = gang_q;
    msb_d   = msb_q;
    spare_d = spare_q;
    flt_d   = flt_q;
    cctl_d  = cctl_q;
    sel_d   = sel_q;
    if (we_i) begin
      if (addr_i == A_CTRL)  glob_d  = wdata_i[0];
      if (addr_i == A_SPARE) spare_d = wdata_i;
      if (addr_i == A_ENSET) en_d    = en_q | wdata_i[N-1:0];
      if (addr_i == A_ENCLR) en_d    = en_q & ~wdata_i[N-1:0];
      if (addr_i == A_IESET) ie_d    = ie_q | wdata_i[N-1:0];
      if (addr_i == A_IECLR) ie_d    = ie_q & ~wdata_i[N-1:0];
      if (addr_i == A_GANG)  gang_d  = wdata_i[N-1:0];
      if (addr_i == A_MSBM)  msb_d   = wdata_i[N-1:0];
      for (int i = 0; i < NFLT; i++) begin
        if (addr_i == A_FLT + AW'(4 * i)) flt_d[i] = wdata_i;
      end
      for (int n = 0; n < N; n++) begin
        if (addr_i == A_CCTL + AW'(8 * n)) cctl_d[n] = wdata_i;
        if (addr_i == A_ESEL + AW'(8 * n)) sel_d[n]  = wdata_i[SEL_W-1:0];
      end
    end
  end

  // registers, enabled by the write strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_q  <= 1'b0;
      en_q    <= '0;
      ie_q    <= '0;
      gang_q  <= '0;
      msb_q   <= '0;
      spare_q <= '0;
      flt_q   <= '0;
      cctl_q  <= '0;
      sel_q   <= '0;
    end else if (we_i) begin
      glob_q  <= glob_d;
      en_q    <= en_d;
      ie_q    <= ie_d;
      gang_q  <= gang_d;
      msb_q   <= msb_d;
      spare_q <= spare_d;
      flt_q   <= flt_d;
      cctl_q  <= cctl_d;
      sel_q   <= sel_d;
    end
  end

  // read side
  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)                        rdata_o[0]     = glob_q;
    if (addr_i == A_SPARE)                       rdata_o        = spare_q;
    if (addr_i == A_ENSET || addr_i == A_ENCLR)  rdata_o[N-1:0] = en_q;
    if (addr_i == A_IESET || addr_i == A_IECLR)  rdata_o[N-1:0] = ie_q;
    if (addr_i == A_GANG)                        rdata_o[N-1:0] = gang_q;
    if (addr_i == A_MSBM)                        rdata_o[N-1:0] = msb_q;
    for (int i = 0; i < NFLT; i++) begin
      if (addr_i == A_FLT + AW'(4 * i)) rdata_o = flt_q[i];
    end
    for (int n = 0; n < N; n++) begin
      if (addr_i == A_CCTL + AW'(8 * n)) rdata_o = cctl_q[n];
      if (addr_i == A_ESEL + AW'(8 * n)) rdata_o[SEL_W-1:0] = sel_q[n];
    end
  end

  assign glob_en_o  = glob_q;
  assign clr_all_o  = we_i && (addr_i == A_CTRL) && wdata_i[1];
  assign cnt_en_o   = en_q;
  assign int_en_o   = ie_q;
  assign gang_o     = gang_q;
  assign msb_mode_o = msb_q;
  assign sel_o      = sel_q;
endmodule

// File: rtl/evctr_incgen.sv
module evctr_incgen import evctr_pkg::*; #(
  parameter int unsigned N     = NCTR,
  parameter int unsigned CTR_W = CW,
  parameter int unsigned SEL_W = SELW
) (
  input  logic                     glob_en_i,
  input  logic [N-1:0]             cnt_en_i,
  input  logic [N-1:0]             gang_i,
  input  logic [N-1:0]             hold_i,
  input  logic [N-1:0][SEL_W-1:0]  sel_i,
  input  logic [NEV-1:0]           ev_i,
  input  logic [N-1:0][CTR_W-1:0]  cnt_i,
  output logic [N-1:0]             inc_o
);
  logic [N-1:0] src;
  logic [N-1:0] wrap;

  // Walk counters upward so an odd counter sees the wrap of its even partner
  always_comb begin
    src   = '0;
    wrap  = '0;
    inc_o = '0;
    for (int n = 0; n < N; n++) begin
      src[n] = pick_event(sel_i[n], ev_i);
      if (((n % 2) == 1) && gang_i[n]) src[n] = wrap[n & ~1];
      inc_o[n] = glob_en_i & cnt_en_i[n] & src[n] & ~hold_i[n];
      wrap[n]  = inc_o[n] & (&cnt_i[n]);
    end
  end
endmodule

// File: rtl/evctr_slice.sv
module evctr_slice #(
  parameter int unsigned CTR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [CTR_W-1:0]  wdata_i,
  input  logic              inc_i,
  input  logic              msb_mode_i,
  output logic [CTR_W-1:0]  cnt_o,
  output logic              ovf_o
);
  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic             upd;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (wr_i)  cnt_d = wdata_i;
    else if (inc_i) cnt_d = cnt_q + CTR_W'(1);
  end

  assign upd = clr_i | wr_i | inc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  // inc_i is already suppressed by a clear or a write
  assign ovf_o = inc_i & (msb_mode_i ? (&cnt_q[CTR_W-2:0]) : (&cnt_q));
  assign cnt_o = cnt_q;
endmodule

// File: rtl/evctr_ovf.sv
module evctr_ovf import evctr_pkg::*; #(
  parameter int unsigned N = NCTR
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_all_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [N-1:0]   set_i,
  input  logic [N-1:0]   int_en_i,
  output logic [N-1:0]   flags_o,
  output logic           irq_o
);
  logic [N-1:0] flg_q, flg_d, w1c;
  logic         upd;

  assign w1c = (we_i && addr_i == A_OVF) ? wdata_i[N-1:0] : '0;

  always_comb begin
    if (clr_all_i) flg_d = '0;
    else           flg_d = (flg_q & ~w1c) | set_i;
  end

  assign upd = clr_all_i | (|w1c) | (|set_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  flg_q <= '0;
    else if (upd) flg_q <= flg_d;
  end

  assign flags_o = flg_q;
  assign irq_o   = |(flg_q & int_en_i);
endmodule

// File: rtl/evctr_bank.sv
module evctr_bank import evctr_pkg::*; #(
  parameter int unsigned NUM_CTR = NCTR,
  parameter int unsigned CTR_W   = CW,
  parameter int unsigned SEL_W   = SELW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NEV-1:0]  evt_i,
  output logic            irq_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sq;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_sync_n = rst_sq[1];

  logic                           glob_en, clr_all;
  logic [NUM_CTR-1:0]             cnt_en, int_en, gang, msb_mode;
  logic [NUM_CTR-1:0][SEL_W-1:0]  sel;
  logic [DW-1:0]                  cfg_rdata;
  logic [NUM_CTR-1:0][CTR_W-1:0]  cnt_all;
  logic [NUM_CTR-1:0]             wr_hit, hold, inc, ovf_set, ovf_flags;

  evctr_cfg #(.N(NUM_CTR), .SEL_W(SEL_W)) u_cfg (
    .clk_i(clk), .rst_ni(rst_sync_n), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .glob_en_o(glob_en), .clr_all_o(clr_all),
    .cnt_en_o(cnt_en), .int_en_o(int_en), .gang_o(gang),
    .msb_mode_o(msb_mode), .sel_o(sel), .rdata_o(cfg_rdata)
  );

  assign hold = wr_hit | {NUM_CTR{clr_all}};

  evctr_incgen #(.N(NUM_CTR), .CTR_W(CTR_W), .SEL_W(SEL_W)) u_inc (
    .glob_en_i(glob_en), .cnt_en_i(cnt_en), .gang_i(gang), .hold_i(hold),
    .sel_i(sel), .ev_i(evt_i), .cnt_i(cnt_all), .inc_o(inc)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    assign wr_hit[g] = reg_we && (reg_addr == A_VAL + AW'(8 * g));
    evctr_slice #(.CTR_W(CTR_W)) u_slice (
      .clk_i(clk), .rst_ni(rst_sync_n), .clr_i(clr_all), .wr_i(wr_hit[g]),
      .wdata_i(reg_wdata[CTR_W-1:0]), .inc_i(inc[g]),
      .msb_mode_i(msb_mode[g]), .cnt_o(cnt_all[g]), .ovf_o(ovf_set[g])
    );
  end

  evctr_ovf #(.N(NUM_CTR)) u_ovf (
    .clk_i(clk), .rst_ni(rst_sync_n), .clr_all_i(clr_all), .we_i(reg_we),
    .addr_i(reg_addr), .wdata_i(reg_wdata), .set_i(ovf_set),
    .int_en_i(int_en), .flags_o(ovf_flags), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata = cfg_rdata;
    if (reg_addr == A_OVF) reg_rdata = reg_rdata | DW'(ovf_flags);
    for (int n = 0; n < NUM_CTR; n++) begin
      if (reg_addr == A_VAL + AW'(8 * n)) reg_rdata = reg_rdata | DW'(cnt_all[n]);
    end
  end
endmodule

// File: rtl/evctr_chk.sv
module evctr_chk import evctr_pkg::*; #(
  parameter int unsigned N     = NCTR,
  parameter int unsigned CTR_W = CW
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     we_i,
  input logic [AW-1:0]            addr_i,
  input logic [DW-1:0]            wdata_i,
  input logic                     glob_en_i,
  input logic [N-1:0][CTR_W-1:0]  cnt_i,
  input logic [N-1:0]             flags_i,
  input logic                     irq_i
);
  // R4: bank disabled and no write -> nothing moves
  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_en_i && !we_i) |=> $stable(cnt_i));

  // R4: clear pulse empties counters and flags
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL && wdata_i[1]) |=> (cnt_i == '0 && flags_i == '0));

  // R9: flags only fall through a register write
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (($past(flags_i) & ~flags_i) == '0));

  // R10: a raised interrupt holds until software writes
  p_irq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !we_i) |=> irq_i);

  for (genvar g = 0; g < N; g++) begin : g_c
    // R2: at most one step per clock without a write
    p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> (cnt_i[g] == $past(cnt_i[g]) ||
                 cnt_i[g] == $past(cnt_i[g]) + CTR_W'(1)));
    // R5: a value write lands on the next edge
    p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_VAL + AW'(8 * g)) |=> cnt_i[g] == $past(wdata_i[CTR_W-1:0]));
  end
endmodule

bind evctr_bank evctr_chk #(.N(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk_i(clk), .rst_ni(rst_sync_n), .we_i(reg_we), .addr_i(reg_addr),
  .wdata_i(reg_wdata), .glob_en_i(glob_en), .cnt_i(cnt_all),
  .flags_i(ovf_flags), .irq_i(irq_o)
);

// File: tb/sim_evctr_bank.sv
`timescale 1ns/1ps
module sim_evctr_bank;
  localparam logic [11:0] CTRL = 12'h500, SPARE = 12'h504, ENS = 12'h508,
    ENC = 12'h50C, IES = 12'h510, IEC = 12'h514, GANG = 12'h718,
    OVF = 12'h740, MSBM = 12'h96C, FLT = 12'h300, CCTL = 12'h120,
    ESEL = 12'h220, VAL = 12'h420;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  evt = '0;
  logic        irq;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  evctr_bank u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] e);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, e);
  endtask

  task automatic pulse(input logic [6:0] ev, input int n);
    evt = ev;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic quiesce();
    wr(ENC, 32'hFF); wr(IEC, 32'hFF); wr(GANG, 0); wr(MSBM, 0); wr(CTRL, 3);
  endtask

  task automatic t_reset();
    rdchk("R1 ctrl", CTRL, 0);   rdchk("R1 en", ENS, 0);
    rdchk("R1 ie", IES, 0);      rdchk("R1 gang", GANG, 0);
    rdchk("R1 msb", MSBM, 0);    rdchk("R1 ovf", OVF, 0);
    rdchk("R1 val0", VAL, 0);    rdchk("R1 val7", VAL + 12'd56, 0);
    rdchk("R1 sel3", ESEL + 12'd24, 0);
    rdchk("R1 unmapped 0x004", 12'h004, 0);
    rdchk("R1 unmapped 0x800", 12'h800, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_count();
    quiesce();
    wr(ESEL, 32'h01); wr(ESEL + 12'd8, 32'h20);
    wr(ESEL + 12'd16, 32'h25); wr(ESEL + 12'd24, 32'h77);
    wr(ENS, 32'h0F);
    pulse(7'b0000011, 5);
    rdchk("R2 cycles count", VAL, 5);
    rdchk("R2 read-hit count", VAL + 12'd8, 5);
    rdchk("R2 idle write-miss", VAL + 12'd16, 0);
    rdchk("R2 unused code", VAL + 12'd24, 0);
    pulse(7'b1000000, 2);
    rdchk("R2 write-miss count", VAL + 12'd16, 2);
    rdchk("R4 bit1 reads 0", CTRL, 1);
    wr(CTRL, 0);
    pulse(7'h7F, 4);
    rdchk("R4 global off frozen", VAL, 5);
    wr(CTRL, 2);
    rdchk("R4 clear counter", VAL, 0);
    rdchk("R4 clear counter 2", VAL + 12'd16, 0);
  endtask

  task automatic t_enables();
    quiesce();
    wr(ENS, 32'h05); rdchk("R3 set", ENS, 32'h05);
    wr(ENS, 32'h02); rdchk("R3 set or", ENS, 32'h07);
    wr(ENC, 32'h01); rdchk("R3 clear", ENS, 32'h06);
    wr(ENC, 32'h00); rdchk("R3 zero no effect", ENC, 32'h06);
    wr(IES, 32'h81); rdchk("R3 ie set", IEC, 32'h81);
    wr(IEC, 32'h80); rdchk("R3 ie clear", IES, 32'h01);
    wr(ESEL, 1); wr(ESEL + 12'd8, 1);
    wr(ENC, 32'hFF); wr(ENS, 32'h02);
    pulse(7'b1, 3);
    rdchk("R3 disabled counter", VAL, 0);
    rdchk("R3 enabled counter", VAL + 12'd8, 3);
  endtask

  task automatic t_write();
    quiesce();
    wr(ESEL, 1); wr(ENS, 1);
    evt = 7'b1;
    wr(VAL, 32'h100);
    evt = '0;
    rdchk("R5 write beats increment", VAL, 32'h100);
    pulse(7'b1, 2);
    rdchk("R5 counts on from loaded value", VAL, 32'h102);
  endtask

  task automatic t_gang();
    quiesce();
    wr(ESEL, 1); wr(ESEL + 12'd8, 1); wr(ENS, 3); wr(GANG, 2);
    wr(VAL, 32'hFFFF_FFFE); wr(VAL + 12'd8, 5);
    pulse(7'b1, 3);
    rdchk("R6 low word", VAL, 1);
    rdchk("R6 high word carry", VAL + 12'd8, 6);
    rdchk("R6 gang readback", GANG, 2);
    wr(CTRL, 3); wr(GANG, 1);
    pulse(7'b1, 3);
    rdchk("R6 even bit no effect c0", VAL, 3);
    rdchk("R6 even bit no effect c1", VAL + 12'd8, 3);
  endtask

  task automatic t_wrap();
    quiesce();
    wr(ESEL + 12'd16, 1); wr(ESEL + 12'd24, 1); wr(ESEL + 12'd32, 1);
    wr(ENS, 32'h1C); wr(IES, 32'h04);
    wr(VAL + 12'd16, 32'hFFFF_FFFF); wr(VAL + 12'd24, 32'h7FFF_FFFF);
    wr(VAL + 12'd32, 32'hFFFF_FFFF);
    chk("R10 irq low before", {31'd0, irq}, 0);
    pulse(7'b1, 1);
    rdchk("R7 wrap flags", OVF, 32'h14);
    rdchk("R7 wrapped value", VAL + 12'd16, 0);
    chk("R10 irq high", {31'd0, irq}, 1);
    wr(OVF, 0);
    rdchk("R9 zero write keeps flags", OVF, 32'h14);
    pulse(7'b0, 5);
    chk("R10 irq holds", {31'd0, irq}, 1);
    wr(OVF, 32'h04);
    rdchk("R9 w1c", OVF, 32'h10);
    chk("R10 irq drops", {31'd0, irq}, 0);
    wr(OVF, 32'hFF);
    wr(VAL + 12'd16, 32'hFFFF_FFFF);
    evt = 7'b1;
    wr(OVF, 32'h04);
    evt = '0;
    rdchk("R9 set wins over clear", OVF, 32'h04);
  endtask

  task automatic t_msb();
    quiesce();
    wr(MSBM, 32'h20);
    rdchk("R8 mode readback", MSBM, 32'h20);
    wr(ESEL + 12'd40, 1); wr(ENS, 32'h20);
    wr(VAL + 12'd40, 32'h7FFF_FFFE);
    pulse(7'b1, 1);
    rdchk("R8 no flag before toggle", OVF, 0);
    pulse(7'b1, 1);
    rdchk("R8 rising top bit", OVF, 32'h20);
    rdchk("R8 value", VAL + 12'd40, 32'h8000_0000);
    wr(OVF, 32'hFF);
    wr(VAL + 12'd40, 32'hFFFF_FFFF);
    pulse(7'b1, 1);
    rdchk("R8 falling top bit", OVF, 32'h20);
  endtask

  task automatic t_store();
    quiesce();
    wr(SPARE, 32'hA5A5_5A5A);
    for (int i = 0; i < 6; i++) wr(FLT + 12'(4 * i), 32'hF0 + 32'(i));
    for (int n = 0; n < 8; n++) wr(CCTL + 12'(8 * n), 32'hC00 + 32'(n));
    wr(ESEL + 12'd48, 32'h1AB);
    rdchk("R11 spare", SPARE, 32'hA5A5_5A5A);
    for (int i = 0; i < 6; i++) rdchk("R11 filter", FLT + 12'(4 * i), 32'hF0 + 32'(i));
    for (int n = 0; n < 8; n++) rdchk("R11 cctl", CCTL + 12'(8 * n), 32'hC00 + 32'(n));
    rdchk("R11 selector width", ESEL + 12'd48, 32'hAB);
    wr(ESEL + 12'd56, 1); wr(ENS, 32'h80);
    pulse(7'b1, 2);
    rdchk("R11 counting unaffected", VAL + 12'd56, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_count();
    t_enables();
    t_write();
    t_gang();
    t_wrap();
    t_msb();
    t_store();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule